// File: doc/BRIEF.md
# Dual-Channel Memory Address Mapper

This block sits between a memory request source and two DRAM channel controllers. Each request carries a physical byte address. The block decides which of the two channels serves it and computes the address inside that channel. Software sets three static inputs: the capacity of each channel, counted in 64-byte lines, and a two-bit mapping mode. The mode chooses one of four layouts. In the first, all traffic goes to one populated channel. In the second, both channels are fully striped. In the third, one channel is stacked on top of the other. In the fourth, the bottom of the space is striped and the surplus of the larger channel sits above it.

Striping works at cache-line granularity. The address bit just above the line offset picks the channel, and that bit is squeezed out of the local address. A request that falls beyond the memory that the selected layout can reach is not sent to either channel. It is reported on an error output instead. The decode is combinational, and its result is captured by one output register, so each result shows up one clock after its request.

Top module: `dcm_addr_mapper`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, map_valid, map_chan_a, map_chan_b and map_err are 0 and map_addr is zero, even if a request is presented during reset.
- R2: A request with req_valid high produces map_valid high exactly one clock later. A cycle with no request produces map_valid, both strobes and map_err low on the following clock. Back-to-back requests give back-to-back results in order.
- R3: map_chan_a and map_chan_b are never high together. Either strobe is high only when map_valid is high and map_err is low.
- R4: In striped mode (cfg_mode = 1), address bit 6 selects the channel: 0 gives channel A, 1 gives channel B. The local address is the request address with bit 6 removed, so bits above it shift down by one and bits 5:0 are kept.
- R5: In striped mode, reachable memory is twice the smaller capacity. A request whose line index (address bits above bit 5) is at or beyond that is out of range.
- R6: In split mode (cfg_mode = 3), line indices below twice the smaller capacity are striped as in R4. Line indices from that point up to the sum of the capacities go to the larger channel, with local line index equal to the request line index minus the smaller capacity and the offset bits kept.
- R7: In split mode with equal capacities, the whole space up to the sum of the capacities is striped.
- R8: In stacked mode (cfg_mode = 2), line indices below the channel A capacity go to channel A with the address unchanged. Line indices from there up to the sum of the capacities go to channel B, with local line index equal to the request line index minus the channel A capacity.
- R9: In single mode (cfg_mode = 0), every request goes to channel A with its address unchanged if channel A's capacity is nonzero, otherwise to channel B. The reachable range is that channel's capacity.
- R10: An out-of-range request sets map_valid and map_err, raises no strobe, and drives map_addr to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Physical byte address of the request |
| cfg_mode | input | 2 | Layout: 0 single, 1 striped, 2 stacked, 3 split |
| cfg_cap_a | input | CAP_W | Channel A capacity in 64-byte lines |
| cfg_cap_b | input | CAP_W | Channel B capacity in 64-byte lines |
| map_valid | output | 1 | Result present (one cycle after request) |
| map_chan_a | output | 1 | Request routed to channel A |
| map_chan_b | output | 1 | Request routed to channel B |
| map_err | output | 1 | Request beyond reachable memory |
| map_addr | output | ADDR_W | Channel-local byte address |

## Verification
The range check and the zone choice look at the same line index in the same cycle. Their thresholds differ, and they disagree exactly at the zone edges. Vectors are therefore placed on the last striped line and the first upper-zone line of split mode, on the last line of the larger channel, and on the line equal to the total capacity. At each of these points the bench compares the strobe, the error flag and the local address together. The equal-capacity split case puts the range limit right at the top of the striped zone, so the upper zone never claims a line. A back-to-back pair of striped requests confirms that a result from one request does not bleed into the next.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

   typedef enum logic [1:0] {
      MAP_SINGLE = 2'd0,
      MAP_STRIPE = 2'd1,
      MAP_STACK  = 2'd2,
      MAP_SPLIT  = 2'd3
   } map_mode_e;

   typedef struct packed {
      logic oor;
      logic to_b;
   } route_t;

endpackage

// File: rtl/dcm_zone_calc.sv
module dcm_zone_calc #(
   parameter int CAP_W = 13
) (
   input  dcm_pkg::map_mode_e mode,
   input  logic [CAP_W-1:0]   cap_a,
   input  logic [CAP_W-1:0]   cap_b,
   output logic [CAP_W:0]     limit,
   output logic [CAP_W:0]     split,
   output logic [CAP_W-1:0]   small_cap,
   output logic               big_is_b,
   output logic               single_b
);
   import dcm_pkg::*;

   logic [CAP_W:0] total;

   assign small_cap = (cap_a < cap_b) ? cap_a : cap_b;
   assign big_is_b  = cap_b > cap_a;
   assign single_b  = (cap_a == '0);
   assign split     = {small_cap, 1'b0};
   assign total     = {1'b0, cap_a} + {1'b0, cap_b};

   always_comb begin
      case (mode)
         MAP_SINGLE: limit = single_b ? {1'b0, cap_b} : {1'b0, cap_a};
         MAP_STRIPE: limit = split;
         default:    limit = total;
      endcase
   end
endmodule

// File: rtl/dcm_line_router.sv
module dcm_line_router #(
   parameter int ADDR_W    = 20,
   parameter int LINE_BITS = 6,
   parameter int CAP_W     = 13
) (
   input  logic [ADDR_W-1:0]  addr,
   input  dcm_pkg::map_mode_e mode,
   input  logic [CAP_W-1:0]   cap_a,
   input  logic [CAP_W:0]     limit,
   input  logic [CAP_W:0]     split,
   input  logic [CAP_W-1:0]   small_cap,
   input  logic               big_is_b,
   input  logic               single_b,
   output dcm_pkg::route_t    route,
   output logic [ADDR_W-1:0]  local_addr
);
   import dcm_pkg::*;

   localparam int LW = ADDR_W - LINE_BITS;
   localparam int SW = LW + 1;

   logic [LW-1:0]        line;
   logic [LINE_BITS-1:0] off;
   logic [SW-1:0]        line_x;
   logic [ADDR_W-1:0]    squeezed;

   assign line     = addr[ADDR_W-1:LINE_BITS];
   assign off      = addr[LINE_BITS-1:0];
   assign line_x   = SW'(line);
   assign squeezed = {1'b0, line[LW-1:1], off};

   always_comb begin
      route.oor  = line_x >= SW'(limit);
      route.to_b = 1'b0;
      local_addr = addr;
      case (mode)
         MAP_SINGLE: begin
            route.to_b = single_b;
            local_addr = addr;
         end
         MAP_STRIPE: begin
            route.to_b = line[0];
            local_addr = squeezed;
         end
         MAP_STACK: begin
            if (line_x < SW'(cap_a)) begin
               route.to_b = 1'b0;
               local_addr = addr;
            end else begin
               route.to_b = 1'b1;
               local_addr = {line - LW'(cap_a), off};
            end
         end
         default: begin
            if (line_x < SW'(split)) begin
               route.to_b = line[0];
               local_addr = squeezed;
            end else begin
               route.to_b = big_is_b;
               local_addr = {line - LW'(small_cap), off};
            end
         end
      endcase
   end
endmodule

// File: rtl/dcm_out_stage.sv
module dcm_out_stage #(
   parameter int ADDR_W   = 20,
   parameter bit DATA_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              v_d,
   input  logic              a_d,
   input  logic              b_d,
   input  logic              err_d,
   input  logic [ADDR_W-1:0] addr_d,
   output logic              v_q,
   output logic              a_q,
   output logic              b_q,
   output logic              err_q,
   output logic [ADDR_W-1:0] addr_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q   <= 1'b0;
         a_q   <= 1'b0;
         b_q   <= 1'b0;
         err_q <= 1'b0;
      end else begin
         v_q   <= v_d;
         a_q   <= a_d;
         b_q   <= b_d;
         err_q <= err_d;
      end
   end

   generate
      if (DATA_RST) begin : g_addr_rst
         always_ff @(posedge clk) begin
            if (!rst_n) addr_q <= '0;
            else        addr_q <= addr_d;
         end
      end else begin : g_addr_free
         always_ff @(posedge clk) begin
            addr_q <= addr_d;
         end
      end
   endgenerate
endmodule

// File: rtl/dcm_addr_mapper.sv
module dcm_addr_mapper #(
   parameter int ADDR_W    = 20,
   parameter int LINE_BITS = 6,
   parameter int CAP_W     = 13,
   parameter bit DATA_RST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        cfg_mode,
   input  logic [CAP_W-1:0]  cfg_cap_a,
   input  logic [CAP_W-1:0]  cfg_cap_b,
   output logic              map_valid,
   output logic              map_chan_a,
   output logic              map_chan_b,
   output logic              map_err,
   output logic [ADDR_W-1:0] map_addr
);
   import dcm_pkg::*;

   localparam int LW = ADDR_W - LINE_BITS;

   generate
      if (LINE_BITS < 1) begin : g_bad_line
         $error("LINE_BITS must be at least 1");
      end
      if (LW < 2) begin : g_bad_addr
         $error("ADDR_W must leave at least two line-index bits");
      end
      if (CAP_W < 1 || CAP_W > LW) begin : g_bad_cap
         $error("CAP_W must lie between 1 and the line-index width");
      end
   endgenerate

   map_mode_e         mode;
   logic [CAP_W:0]    limit;
   logic [CAP_W:0]    split;
   logic [CAP_W-1:0]  small_cap;
   logic              big_is_b;
   logic              single_b;
   route_t            route;
   logic [ADDR_W-1:0] local_addr;
   logic              fire;

   assign mode = map_mode_e'(cfg_mode);

   dcm_zone_calc #(.CAP_W(CAP_W)) u_zone (
      .mode      (mode),
      .cap_a     (cfg_cap_a),
      .cap_b     (cfg_cap_b),
      .limit     (limit),
      .split     (split),
      .small_cap (small_cap),
      .big_is_b  (big_is_b),
      .single_b  (single_b)
   );

   dcm_line_router #(
      .ADDR_W    (ADDR_W),
      .LINE_BITS (LINE_BITS),
      .CAP_W     (CAP_W)
   ) u_route (
      .addr       (req_addr),
      .mode       (mode),
      .cap_a      (cfg_cap_a),
      .limit      (limit),
      .split      (split),
      .small_cap  (small_cap),
      .big_is_b   (big_is_b),
      .single_b   (single_b),
      .route      (route),
      .local_addr (local_addr)
   );

   assign fire = req_valid && !route.oor;

   dcm_out_stage #(.ADDR_W(ADDR_W), .DATA_RST(DATA_RST)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .v_d    (req_valid),
      .a_d    (fire && !route.to_b),
      .b_d    (fire && route.to_b),
      .err_d  (req_valid && route.oor),
      .addr_d (fire ? local_addr : '0),
      .v_q    (map_valid),
      .a_q    (map_chan_a),
      .b_q    (map_chan_b),
      .err_q  (map_err),
      .addr_q (map_addr)
   );
endmodule

// File: rtl/dcm_addr_mapper_chk.sv
module dcm_addr_mapper_chk #(
   parameter int ADDR_W    = 20,
   parameter int LINE_BITS = 6,
   parameter int CAP_W     = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        cfg_mode,
   input logic [CAP_W-1:0]  cfg_cap_a,
   input logic [CAP_W-1:0]  cfg_cap_b,
   input logic              map_valid,
   input logic              map_chan_a,
   input logic              map_chan_b,
   input logic              map_err,
   input logic [ADDR_W-1:0] map_addr
);
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(map_chan_a && map_chan_b)); // R3

   AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (map_chan_a || map_chan_b) |-> (map_valid && !map_err)); // R3

   AST_REQ_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> map_valid); // R2

   AST_IDLE_GIVES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!map_valid && !map_chan_a && !map_chan_b && !map_err)); // R2

   AST_ERR_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      map_err |-> (map_valid && map_addr == '0)); // R10

   AST_STRIPE_EVEN_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cfg_mode == 2'd1 && !req_addr[LINE_BITS]) |=> !map_chan_b); // R4

   AST_SINGLE_PREFERS_A: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cfg_mode == 2'd0 && cfg_cap_a != '0) |=> !map_chan_b); // R9

   AST_SINGLE_EMPTY_A: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cfg_mode == 2'd0 && cfg_cap_a == '0) |=> !map_chan_a); // R9
endmodule

bind dcm_addr_mapper dcm_addr_mapper_chk #(
   .ADDR_W    (ADDR_W),
   .LINE_BITS (LINE_BITS),
   .CAP_W     (CAP_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_addr   (req_addr),
   .cfg_mode   (cfg_mode),
   .cfg_cap_a  (cfg_cap_a),
   .cfg_cap_b  (cfg_cap_b),
   .map_valid  (map_valid),
   .map_chan_a (map_chan_a),
   .map_chan_b (map_chan_b),
   .map_err    (map_err),
   .map_addr   (map_addr)
);

// File: tb/dcm_addr_mapper_bench.sv
module dcm_addr_mapper_bench;
   localparam int CLK_P  = 10;
   localparam int ADDR_W = 20;
   localparam int CAP_W  = 13;
   localparam int NVEC   = 22;

   typedef struct packed {
      logic [1:0]        mode;
      logic [CAP_W-1:0]  ca;
      logic [CAP_W-1:0]  cb;
      logic [ADDR_W-1:0] addr;
      logic              err;
      logic              a;
      logic              b;
      logic [ADDR_W-1:0] exp;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{2'd1, 13'h100, 13'h100, 20'h00000, 1'b0, 1'b1, 1'b0, 20'h00000}, // R4 line 0
      '{2'd1, 13'h100, 13'h100, 20'h00040, 1'b0, 1'b0, 1'b1, 20'h00000}, // R4 line 1
      '{2'd1, 13'h100, 13'h100, 20'h00085, 1'b0, 1'b1, 1'b0, 20'h00045}, // R4 line 2 offset kept
      '{2'd1, 13'h100, 13'h100, 20'h000C7, 1'b0, 1'b0, 1'b1, 20'h00047}, // R4 line 3
      '{2'd1, 13'h100, 13'h040, 20'h01FC0, 1'b0, 1'b0, 1'b1, 20'h00FC0}, // R5 last striped line
      '{2'd1, 13'h100, 13'h040, 20'h02000, 1'b1, 1'b0, 1'b0, 20'h00000}, // R5 first unreachable
      '{2'd3, 13'h100, 13'h040, 20'h01F83, 1'b0, 1'b1, 1'b0, 20'h00FC3}, // R6 striped zone
      '{2'd3, 13'h100, 13'h040, 20'h01FC0, 1'b0, 1'b0, 1'b1, 20'h00FC0}, // R6 last striped line
      '{2'd3, 13'h100, 13'h040, 20'h02000, 1'b0, 1'b1, 1'b0, 20'h01000}, // R6 first upper line
      '{2'd3, 13'h100, 13'h040, 20'h04FFF, 1'b0, 1'b1, 1'b0, 20'h03FFF}, // R6 top of larger channel
      '{2'd3, 13'h100, 13'h040, 20'h05000, 1'b1, 1'b0, 1'b0, 20'h00000}, // R10 at total
      '{2'd3, 13'h040, 13'h100, 20'h02410, 1'b0, 1'b0, 1'b1, 20'h01410}, // R6 larger is B
      '{2'd3, 13'h080, 13'h080, 20'h03FC0, 1'b0, 1'b0, 1'b1, 20'h01FC0}, // R7 equal caps top line
      '{2'd3, 13'h080, 13'h080, 20'h04000, 1'b1, 1'b0, 1'b0, 20'h00000}, // R7 equal caps beyond
      '{2'd2, 13'h100, 13'h040, 20'h03FC1, 1'b0, 1'b1, 1'b0, 20'h03FC1}, // R8 top of A
      '{2'd2, 13'h100, 13'h040, 20'h04002, 1'b0, 1'b0, 1'b1, 20'h00002}, // R8 bottom of B
      '{2'd2, 13'h100, 13'h040, 20'h04FC0, 1'b0, 1'b0, 1'b1, 20'h00FC0}, // R8 top of B
      '{2'd2, 13'h100, 13'h040, 20'h05000, 1'b1, 1'b0, 1'b0, 20'h00000}, // R10 stacked beyond
      '{2'd0, 13'h100, 13'h000, 20'h01040, 1'b0, 1'b1, 1'b0, 20'h01040}, // R9 only A
      '{2'd0, 13'h000, 13'h040, 20'h00FC0, 1'b0, 1'b0, 1'b1, 20'h00FC0}, // R9 only B
      '{2'd0, 13'h000, 13'h040, 20'h01000, 1'b1, 1'b0, 1'b0, 20'h00000}, // R9 beyond B
      '{2'd1, 13'h100, 13'h000, 20'h00000, 1'b1, 1'b0, 1'b0, 20'h00000}  // R5 empty B, no stripe
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [1:0]        cfg_mode = 2'd0;
   logic [CAP_W-1:0]  cfg_cap_a = '0;
   logic [CAP_W-1:0]  cfg_cap_b = '0;
   logic              map_valid, map_chan_a, map_chan_b, map_err;
   logic [ADDR_W-1:0] map_addr;

   int total = 0;
   int bad   = 0;

   always #(CLK_P / 2) clk = ~clk;

   dcm_addr_mapper u_dcm_addr_mapper (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .cfg_mode   (cfg_mode),
      .cfg_cap_a  (cfg_cap_a),
      .cfg_cap_b  (cfg_cap_b),
      .map_valid  (map_valid),
      .map_chan_a (map_chan_a),
      .map_chan_b (map_chan_b),
      .map_err    (map_err),
      .map_addr   (map_addr)
   );

   task automatic chk(input string tag, input logic v, input logic e,
                      input logic a, input logic b, input logic [ADDR_W-1:0] ad);
      logic [ADDR_W+3:0] got, exp;
      got = {map_valid, map_err, map_chan_a, map_chan_b, map_addr};
      exp = {v, e, a, b, ad};
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got v/e/a/b/addr=%b%b%b%b/%h expected %b%b%b%b/%h",
                  tag, got[ADDR_W+3], got[ADDR_W+2], got[ADDR_W+1], got[ADDR_W],
                  got[ADDR_W-1:0], v, e, a, b, ad);
      end
   endtask

   task automatic drive(input logic [1:0] m, input logic [CAP_W-1:0] ca,
                        input logic [CAP_W-1:0] cb, input logic [ADDR_W-1:0] ad);
      req_valid = 1'b1;
      cfg_mode  = m;
      cfg_cap_a = ca;
      cfg_cap_b = cb;
      req_addr  = ad;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: request presented during reset leaves outputs quiet
      @(negedge clk);
      drive(2'd1, 13'h100, 13'h100, 20'h00040);
      repeat (2) @(negedge clk);
      chk("R1 during reset", 1'b0, 1'b0, 1'b0, 1'b0, '0);
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", 1'b0, 1'b0, 1'b0, 1'b0, '0);

      for (int i = 0; i < NVEC; i++) begin
         drive(VECS[i].mode, VECS[i].ca, VECS[i].cb, VECS[i].addr);
         @(negedge clk);
         req_valid = 1'b0;
         chk($sformatf("vector %0d", i), 1'b1, VECS[i].err, VECS[i].a,
             VECS[i].b, VECS[i].exp);
      end

      // R2: idle cycle after a request gives no result
      @(negedge clk);
      chk("R2 idle", 1'b0, 1'b0, 1'b0, 1'b0, '0);

      // R2 and R4: back-to-back striped requests stay in order
      drive(2'd1, 13'h100, 13'h100, 20'h000C1);
      @(negedge clk);
      drive(2'd1, 13'h100, 13'h100, 20'h00102);
      chk("R2 first of pair", 1'b1, 1'b0, 1'b0, 1'b1, 20'h00041);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 second of pair", 1'b1, 1'b0, 1'b1, 1'b0, 20'h00082);

      // R10 then R8: out-of-range followed at once by a good request
      drive(2'd2, 13'h010, 13'h010, 20'h00800);
      @(negedge clk);
      drive(2'd2, 13'h010, 13'h010, 20'h00440);
      chk("R10 stacked total", 1'b1, 1'b1, 1'b0, 1'b0, '0);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R8 small stack in B", 1'b1, 1'b0, 1'b0, 1'b1, 20'h00040);

      // R3: no strobe on an idle cycle after the error
      @(negedge clk);
      chk("R3 quiet", 1'b0, 1'b0, 1'b0, 1'b0, '0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule